// File: doc/BRIEF.md
# Locking Watchdog Timer

This block guards a system against software that has stopped making progress. A down-counter, advanced once every fixed group of peripheral clock cycles, runs from a programmable timeout value. Software must restart it in time by writing a two-value key sequence to a dedicated register. If the count runs out, or if the key sequence is broken, the block raises a fault. Depending on a mode bit, the fault either asks the system for a reset or latches an interrupt.

Once software enables the watchdog, it cannot switch it off. Only a hardware reset or a fault of its own clears the enable bit. When the reset response is chosen, the block returns its own enable, mode and timeout state to their power-up values as the request goes out. A status flag survives that self-reset, so that software can later tell why the system restarted.

Top module: `wdt_lock`

## Requirements
- R1: After the hardware reset `rst_n`, `en_o`, `rst_mode_o`, `rst_req_o`, `irq_o` and `flag_o` are 0, `count_o` is 0, and the timeout register holds MIN_TC.
- R2: A write to the control register (offset 0) with bit 0 set makes `en_o` 1. Later control writes with bit 0 clear leave it at 1. Only a hardware reset or a fault clears it.
- R3: While `en_o` is 0, writes to the key register (offset 2) have no effect: the count does not start and no fault is raised.
- R4: While enabled, a key write of 0xAA (low 8 bits) followed by a key write of 0x55 is a valid restart. Idle cycles are allowed between the two writes. At the clock edge that captures the 0x55 write, `count_o` takes the timeout register value. From then on it falls by one every PRE_DIV cycles.
- R5: Without a restart, a fault occurs exactly PRE_DIV × timeout cycles after the edge of the restart. If a restart write falls in that same cycle, the fault wins.
- R6: A write to the timeout register (offset 1) with a value below MIN_TC stores MIN_TC.
- R7: While enabled, a fault is raised by a key write whose value is not 0xAA when no key is pending. A fault is also raised by any write at all, other than a 0x55 key write, that follows a pending 0xAA.
- R8: When control bit 1 (reset response, set-only) is 1, a fault drives `rst_req_o` high for exactly one cycle. At the same time, enable, reset response and the timeout register return to their R1 values.
- R9: When control bit 1 is 0, a fault sets `irq_o`, which then stays 1 until a hardware reset. The fault also clears `en_o` and does not assert `rst_req_o`.
- R10: Every fault sets `flag_o`, and the block's own reset response does not clear it. A control write with bit 2 equal to 0 clears the flag. A control write with bit 2 equal to 1 leaves it unchanged.
- R11: A write to the timeout register does not change a running count. A later valid restart reloads `count_o` from the new timeout value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low hardware reset, clears everything including the flag |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 2 | Register offset: 0 control, 1 timeout, 2 key, 3 unused |
| wr_data | input | CNT_W | Write data |
| en_o | output | 1 | Watchdog enabled |
| rst_mode_o | output | 1 | Fault response is a reset request |
| count_o | output | CNT_W | Current count value |
| rst_req_o | output | 1 | One-cycle reset request to the system reset logic |
| irq_o | output | 1 | Latched watchdog interrupt |
| flag_o | output | 1 | A watchdog fault has occurred |

## Verification
The bench builds the block with CNT_W of 32 and PRE_DIV of 4, and lowers MIN_TC to 16. With that floor, a timeout of 20 expires after 80 cycles, so the exact expiry cycle, the one-step-per-four-cycles decrement and the floor clamp can all be checked cycle for cycle in a short run. Keeping the full 32-bit width and the prescale of four exercises the same counter and prescaler arithmetic that the default build uses.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [1:0] {
    ADDR_CTRL  = 2'd0,
    ADDR_TMO   = 2'd1,
    ADDR_KEY   = 2'd2,
    ADDR_SPARE = 2'd3
  } wdt_addr_e;

  typedef enum logic {
    KEY_IDLE    = 1'b0,
    KEY_PENDING = 1'b1
  } key_state_e;

  localparam logic [7:0] KEY_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_RST_BIT  = 1;
  localparam int CTRL_FLAG_BIT = 2;

endpackage

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       armed,
  input  logic       clear,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_byte,
  output logic       feed_ok,
  output logic       feed_bad
);

  key_state_e state_q, state_d;

  always_comb begin
    feed_ok  = 1'b0;
    feed_bad = 1'b0;
    state_d  = state_q;
    if (armed && wr_en) begin
      if (state_q == KEY_IDLE) begin
        if (wr_addr == ADDR_KEY) begin
          if (wr_byte == KEY_FIRST) state_d = KEY_PENDING;
          else                      feed_bad = 1'b1;
        end
      end else begin
        if (wr_addr == ADDR_KEY && wr_byte == KEY_SECOND) feed_ok  = 1'b1;
        else                                              feed_bad = 1'b1;
        state_d = KEY_IDLE;
      end
    end
    if (!armed || clear) state_d = KEY_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= KEY_IDLE;
    else        state_q <= state_d;
  end

  // R4: a valid restart only completes a pending first key
  a_r4_ok_after_first: assert property (@(posedge clk) disable iff (!rst_n)
    feed_ok |-> state_q == KEY_PENDING);

  // R3: key writes are inert while disabled
  a_r3_inert_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && wr_en && wr_addr == ADDR_KEY) |-> !feed_ok && !feed_bad);

endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int CNT_W   = 32,
  parameter int PRE_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             stop,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             expire
);

  localparam int PRE_W = (PRE_DIV > 2) ? $clog2(PRE_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [PRE_W-1:0] pre_q;
  logic             tick;

  function automatic logic [PRE_W-1:0] next_pre(input logic [PRE_W-1:0] p);
    return (p == PRE_LAST) ? '0 : p + PRE_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c,
                                                  input logic step);
    return step ? c - CNT_ONE : c;
  endfunction

  assign tick   = running && (pre_q == PRE_LAST);
  assign expire = tick && (count == CNT_ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q   <= '0;
      count   <= '0;
      running <= 1'b0;
    end else if (stop) begin
      pre_q   <= '0;
      running <= 1'b0;
    end else if (load) begin
      pre_q   <= '0;
      count   <= reload_val;
      running <= 1'b1;
    end else if (running) begin
      pre_q <= next_pre(pre_q);
      count <= next_count(count, tick);
    end
  end

  // R4: a restart loads the timeout value and starts the count
  a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !stop) |=> (count == $past(reload_val)) && running);

  // R4: one step per prescaler period
  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !load && !stop && pre_q == PRE_LAST) |=> count == $past(count) - CNT_ONE);

  // R5: the fault stops the count before it can wrap
  a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> count != '0);

endmodule

// File: rtl/wdt_ctrl_regs.sv
module wdt_ctrl_regs
  import wdt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int MIN_TC = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fault,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic             en_q,
  output logic             rst_sel_q,
  output logic             flag_q,
  output logic             irq_q,
  output logic             rst_req_q,
  output logic [CNT_W-1:0] tc_q
);

  localparam logic [CNT_W-1:0] TC_FLOOR = CNT_W'(MIN_TC);

  function automatic logic [CNT_W-1:0] floor_tc(input logic [CNT_W-1:0] v);
    return (v < TC_FLOOR) ? TC_FLOOR : v;
  endfunction

  logic ctrl_wr, tmo_wr;
  assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);
  assign tmo_wr  = wr_en && (wr_addr == ADDR_TMO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      rst_sel_q <= 1'b0;
      flag_q    <= 1'b0;
      irq_q     <= 1'b0;
      rst_req_q <= 1'b0;
      tc_q      <= TC_FLOOR;
    end else begin
      rst_req_q <= 1'b0;
      if (fault) begin
        en_q   <= 1'b0;
        flag_q <= 1'b1;
        if (rst_sel_q) begin
          rst_req_q <= 1'b1;
          rst_sel_q <= 1'b0;
          tc_q      <= TC_FLOOR;
        end else begin
          irq_q <= 1'b1;
        end
      end else if (ctrl_wr) begin
        en_q      <= en_q | wr_data[CTRL_EN_BIT];
        rst_sel_q <= rst_sel_q | wr_data[CTRL_RST_BIT];
        if (!wr_data[CTRL_FLAG_BIT]) flag_q <= 1'b0;
      end else if (tmo_wr) begin
        tc_q <= floor_tc(wr_data);
      end
    end
  end

  // R2: enable cannot be cleared by software
  a_r2_enable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !fault) |=> en_q);

  // R6: timeout register never below the floor
  a_r6_tc_floor: assert property (@(posedge clk) disable iff (!rst_n)
    tc_q >= TC_FLOOR);

  // R8: reset request is a single-cycle pulse
  a_r8_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_q |=> !rst_req_q);

  // R9: interrupt stays latched
  a_r9_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> irq_q);

  // R10: every fault leaves the flag set
  a_r10_flag_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> flag_q);

endmodule

// File: rtl/wdt_lock.sv
module wdt_lock #(
  parameter int CNT_W   = 32,
  parameter int PRE_DIV = 4,
  parameter int MIN_TC  = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic             en_o,
  output logic             rst_mode_o,
  output logic [CNT_W-1:0] count_o,
  output logic             rst_req_o,
  output logic             irq_o,
  output logic             flag_o
);

  logic             feed_ok, feed_bad, expire, running, fault, stop;
  logic [CNT_W-1:0] tc;

  assign fault = expire || feed_bad;
  assign stop  = fault || !en_o;

  wdt_ctrl_regs #(.CNT_W(CNT_W), .MIN_TC(MIN_TC)) u_regs (
    .clk(clk), .rst_n(rst_n), .fault(fault),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .en_q(en_o), .rst_sel_q(rst_mode_o), .flag_q(flag_o),
    .irq_q(irq_o), .rst_req_q(rst_req_o), .tc_q(tc)
  );

  wdt_key_seq u_key (
    .clk(clk), .rst_n(rst_n), .armed(en_o), .clear(fault),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_byte(wr_data[7:0]),
    .feed_ok(feed_ok), .feed_bad(feed_bad)
  );

  wdt_countdown #(.CNT_W(CNT_W), .PRE_DIV(PRE_DIV)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(feed_ok), .stop(stop),
    .reload_val(tc), .count(count_o), .running(running), .expire(expire)
  );

  // R3: faults only arise while enabled
  a_r3_fault_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> en_o);

  // R9: interrupt response never requests a reset
  a_r9_no_req_in_irq_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !rst_mode_o) |=> !rst_req_o && irq_o);

  // R5: the counter only runs while enabled
  a_r5_run_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> en_o);

endmodule

// File: tb/tb_wdt_lock.sv
`timescale 1ns/1ps
module tb_wdt_lock;

  localparam int W   = 32;
  localparam int DIV = 4;
  localparam int MIN = 16;
  localparam logic [1:0] A_CTRL = 2'd0, A_TMO = 2'd1, A_KEY = 2'd2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic en_o, rst_mode_o, rst_req_o, irq_o, flag_o;
  logic [W-1:0] count_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  wdt_lock #(.CNT_W(W), .PRE_DIV(DIV), .MIN_TC(MIN)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .en_o(en_o), .rst_mode_o(rst_mode_o), .count_o(count_o),
    .rst_req_o(rst_req_o), .irq_o(irq_o), .flag_o(flag_o)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hw_reset();
    @(negedge clk); rst_n = 1'b0;
    idle(2); rst_n = 1'b1; idle(1);
  endtask

  task automatic feed();
    wr(A_KEY, 32'hAA);
    wr(A_KEY, 32'h55);
  endtask

  task automatic t_reset_state();
    hw_reset();
    chk("R1 en", en_o, 0); chk("R1 mode", rst_mode_o, 0);
    chk("R1 req", rst_req_o, 0); chk("R1 irq", irq_o, 0);
    chk("R1 flag", flag_o, 0); chk("R1 count", count_o, 0);
    wr(A_CTRL, 1); feed();
    chk("R1 default timeout", count_o, MIN);
  endtask

  task automatic t_disabled_inert();
    hw_reset();
    feed(); wr(A_KEY, 32'h12); idle(3);
    chk("R3 no start", count_o, 0);
    chk("R3 no fault irq", irq_o, 0); chk("R3 no fault flag", flag_o, 0);
  endtask

  task automatic t_enable_sticky();
    hw_reset();
    wr(A_CTRL, 1); chk("R2 enabled", en_o, 1);
    wr(A_CTRL, 0); chk("R2 still enabled", en_o, 1);
  endtask

  task automatic t_feed_and_step();
    hw_reset();
    wr(A_CTRL, 1); wr(A_TMO, 40);
    wr(A_KEY, 32'hAA); idle(3); wr(A_KEY, 32'h55);
    chk("R4 load", count_o, 40);
    idle(3); chk("R4 hold in period", count_o, 40);
    idle(1); chk("R4 first step", count_o, 39);
    idle(8); chk("R4 two more steps", count_o, 37);
  endtask

  task automatic t_clamp();
    hw_reset();
    wr(A_CTRL, 1); wr(A_TMO, 3); feed();
    chk("R6 clamp", count_o, MIN);
  endtask

  task automatic t_timeout_reset_mode();
    hw_reset();
    wr(A_CTRL, 3); wr(A_TMO, 20); feed();
    idle(DIV * 20 - 1);
    chk("R5 not yet", rst_req_o, 0); chk("R5 still enabled", en_o, 1);
    idle(1);
    chk("R5/R8 request", rst_req_o, 1); chk("R10 flag set", flag_o, 1);
    chk("R8 enable cleared", en_o, 0); chk("R8 mode cleared", rst_mode_o, 0);
    chk("R9 no irq in reset mode", irq_o, 0);
    idle(1); chk("R8 one-cycle pulse", rst_req_o, 0);
    chk("R10 flag survives", flag_o, 1);
    wr(A_CTRL, 5); chk("R10 write one keeps flag", flag_o, 1);
    feed(); chk("R8 timeout restored", count_o, MIN);
    wr(A_CTRL, 0); chk("R10 write zero clears", flag_o, 0);
  endtask

  task automatic t_bad_after_first();
    hw_reset();
    wr(A_CTRL, 1); wr(A_TMO, 100);
    wr(A_KEY, 32'hAA); wr(A_TMO, 200);
    chk("R7/R9 irq on interrupted key", irq_o, 1);
    chk("R9 enable cleared", en_o, 0); chk("R9 no request", rst_req_o, 0);
    chk("R10 flag", flag_o, 1);
    idle(5); chk("R9 irq held", irq_o, 1);
  endtask

  task automatic t_bad_value();
    hw_reset();
    wr(A_CTRL, 1); wr(A_KEY, 32'h12);
    chk("R7 wrong first key", irq_o, 1);
    hw_reset();
    wr(A_CTRL, 1); wr(A_KEY, 32'hAA); wr(A_KEY, 32'hAA);
    chk("R7 repeated first key", irq_o, 1);
  endtask

  task automatic t_reload_new_tc();
    hw_reset();
    wr(A_CTRL, 1); wr(A_TMO, 40); feed();
    idle(6); wr(A_TMO, 30);
    chk("R11 running count untouched", count_o, 38);
    feed(); chk("R11 reload new value", count_o, 30);
    chk("R11 no fault", irq_o, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset_state();
    t_disabled_inert();
    t_enable_sticky();
    t_feed_and_step();
    t_clamp();
    t_timeout_reset_mode();
    t_bad_after_first();
    t_bad_value();
    t_reload_new_tc();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule